// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt Enable and Pending Register Slice

This block holds the interrupt-control state of one hart that may implement the hypervisor extension. It keeps three words: the machine interrupt-enable word, the machine delegation word and the software-owned part of the pending word. It serves seven register views over them. Each view has its own read mask and its own write mask, so supervisor, hypervisor and virtual-supervisor software see only the bits that belong to them.

Access uses a single-cycle CSR port. The read data is combinational from the current state and the live interrupt inputs. A write takes effect at the next rising clock edge. The write applies only the bits set in the write mask, intersected with the view's writable set.

Some pending bits belong to hardware and follow input pins with no storage: machine software, machine timer, machine external, part of supervisor external, and guest-external. A parameter states whether the hypervisor extension is present.

Top module: `hyp_irq_csr`

## Requirements
- R1: After reset the enable word and the stored pending bits are 0. The delegation word reads 0x1444 when the hypervisor extension is present and 0 when it is absent.
- R2: Address 0x304 (machine enable) reads the enable word. A write changes only bits 1,2,3,5,6,7,9,10,11 and 12. Every other bit reads 0.
- R3: Address 0x303 (delegation) writes only bits 1,2,5,6,9,10. With the hypervisor extension present, bits 2,6,10,12 read 1 after every write, whatever was written.
- R4: Address 0x604 (hypervisor enable) reads the enable word masked with 0x1444. A write changes only those bits of the enable word and leaves the other bits untouched.
- R5: Address 0x144 (supervisor pending) reads pending AND delegation AND 0x222. A write can change only bit 1, and only while delegation bit 1 is 1.
- R6: Address 0x644 (hypervisor pending) reads pending masked with 0x1444. A write can change only bit 2.
- R7: Address 0x645 (virtual-supervisor pending) reads pending masked with 0x444. A write changes only bits 2, 6 and 10.
- R8: Address 0x344 (machine pending) reads the pending word, in which the following bits come from the inputs in the same cycle: bit 3 from machine software, bit 7 from machine timer, bit 11 from machine external, and bit 12 from the guest-external input. Bit 9 is the stored bit ORed with the supervisor external input. A write stores only bits 1,2,5,6,9,10. Writes through any view have no effect on bits 3,7,11 and 12.
- R9: Any other address gives csr_hit=0 and csr_rdata=0 and leaves all state unchanged.
- R10: Without the hypervisor extension, addresses 0x604, 0x644 and 0x645 behave as unknown addresses. Enable bit 12 and pending bit 12 always read 0, and delegation is not forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Per-bit write enable; all zero is a pure read |
| csr_rdata | output | XLEN | View read value (before any write) |
| csr_hit | output | 1 | Address is a served view |
| irq_m_soft | input | 1 | Machine software interrupt line |
| irq_m_timer | input | 1 | Machine timer interrupt line |
| irq_m_ext | input | 1 | Machine external interrupt line |
| irq_s_ext | input | 1 | Supervisor external interrupt line |
| irq_guest_ext | input | 1 | OR of enabled guest-external pending lines |

## Verification
The checks assume that all inputs are synchronous to clk and stable around the rising edge. They also assume that an access presents its address, data and mask for one whole cycle, with read data sampled before that edge. The guest-external line is taken to be already reduced from its per-guest sources.

The stimulus changes every input only on the falling edge. It mixes served and unserved addresses with zero, full and random write masks. It drives the same sequence into a hypervisor instance and a non-hypervisor instance, so both forms of the delegation and guest-external rules are exercised against the same stimulus.

// File: rtl/hyp_irq_csr.sv
module hyp_irq_csr #(
  parameter int XLEN    = 64,
  parameter bit HAS_HYP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [XLEN-1:0] csr_wmask,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  input  logic            irq_m_soft,
  input  logic            irq_m_timer,
  input  logic            irq_m_ext,
  input  logic            irq_s_ext,
  input  logic            irq_guest_ext
);
  localparam logic [11:0] A_MIE  = 12'h304, A_MDLG = 12'h303, A_MIP  = 12'h344,
                          A_SIP  = 12'h144, A_HIE  = 12'h604, A_HIP  = 12'h644,
                          A_HVIP = 12'h645;
  localparam logic [XLEN-1:0] GRP_M  = XLEN'(16'h0888);
  localparam logic [XLEN-1:0] GRP_S  = XLEN'(16'h0222);
  localparam logic [XLEN-1:0] GRP_VS = XLEN'(16'h0444);
  localparam logic [XLEN-1:0] GEXT   = XLEN'(16'h1000);
  localparam logic [XLEN-1:0] GRP_HS = GRP_VS | GEXT;
  localparam logic [XLEN-1:0] ALL_EN = GRP_M | GRP_S | GRP_HS;
  localparam logic [XLEN-1:0] DLG_WR = GRP_S | GRP_VS;
  localparam logic [XLEN-1:0] DLG_FORCE = HAS_HYP ? GRP_HS : '0;
  localparam logic [XLEN-1:0] SSIP   = XLEN'(16'h0002);
  localparam logic [XLEN-1:0] VSSIP  = XLEN'(16'h0004);

  logic [XLEN-1:0] mie_q, mideleg_q, swpend_q;
  logic [XLEN-1:0] hwpend, pend;

  always_comb begin
    hwpend     = '0;
    hwpend[3]  = irq_m_soft;
    hwpend[7]  = irq_m_timer;
    hwpend[9]  = irq_s_ext;
    hwpend[11] = irq_m_ext;
    hwpend[12] = irq_guest_ext & HAS_HYP;
  end
  assign pend = swpend_q | hwpend;

  logic sel_mie, sel_mdlg, sel_mip, sel_sip, sel_hie, sel_hip, sel_hvip;
  assign sel_mie  = csr_en && csr_addr == A_MIE;
  assign sel_mdlg = csr_en && csr_addr == A_MDLG;
  assign sel_mip  = csr_en && csr_addr == A_MIP;
  assign sel_sip  = csr_en && csr_addr == A_SIP;
  assign sel_hie  = csr_en && HAS_HYP && csr_addr == A_HIE;
  assign sel_hip  = csr_en && HAS_HYP && csr_addr == A_HIP;
  assign sel_hvip = csr_en && HAS_HYP && csr_addr == A_HVIP;

  assign csr_hit = sel_mie | sel_mdlg | sel_mip | sel_sip | sel_hie | sel_hip | sel_hvip;

  always_comb begin
    csr_rdata = '0;
    if (sel_mie)  csr_rdata = mie_q;
    if (sel_mdlg) csr_rdata = mideleg_q;
    if (sel_mip)  csr_rdata = pend;
    if (sel_sip)  csr_rdata = pend & mideleg_q & GRP_S;
    if (sel_hie)  csr_rdata = mie_q & GRP_HS;
    if (sel_hip)  csr_rdata = pend & GRP_HS;
    if (sel_hvip) csr_rdata = pend & GRP_VS;
  end

  logic [XLEN-1:0] en_m, dlg_m, pd_m;
  always_comb begin
    en_m = '0;
    if (sel_mie) en_m = csr_wmask & ALL_EN;
    if (sel_hie) en_m = csr_wmask & GRP_HS;
    dlg_m = sel_mdlg ? (csr_wmask & DLG_WR) : '0;
    pd_m = '0;
    if (sel_mip)  pd_m = csr_wmask & DLG_WR;
    if (sel_sip)  pd_m = csr_wmask & SSIP & mideleg_q;
    if (sel_hip)  pd_m = csr_wmask & VSSIP;
    if (sel_hvip) pd_m = csr_wmask & GRP_VS;
  end

  logic [XLEN-1:0] mie_nx;
  always_comb begin
    mie_nx = (mie_q & ~en_m) | (csr_wdata & en_m);
    if (!HAS_HYP) mie_nx = mie_nx & ~GEXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_q     <= '0;
      mideleg_q <= DLG_FORCE;
      swpend_q  <= '0;
    end else begin
      if (sel_mie | sel_hie) mie_q <= mie_nx;
      if (sel_mdlg) mideleg_q <= (mideleg_q & ~dlg_m) | (csr_wdata & dlg_m) | DLG_FORCE;
      swpend_q <= (swpend_q & ~pd_m) | (csr_wdata & pd_m);
    end
  end
endmodule

module hyp_irq_csr_chk #(
  parameter int XLEN    = 64,
  parameter bit HAS_HYP = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_en,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_hit,
  input logic            irq_guest_ext,
  input logic [XLEN-1:0] mie_q
);
  localparam logic [XLEN-1:0] HS  = XLEN'(16'h1444);
  localparam logic [XLEN-1:0] ALL = XLEN'(16'h1EEE);

  // R9
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit |-> csr_rdata == '0);
  // R9
  unknown_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit |=> $stable(mie_q));
  // R3
  dlg_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_HYP && csr_en && csr_addr == 12'h303) |-> (csr_rdata & HS) == HS);
  // R8
  guest_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == 12'h344) |-> csr_rdata[12] == (irq_guest_ext && HAS_HYP));
  // R2
  en_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == 12'h304) |-> (csr_rdata & ~ALL) == '0);
  // R5
  sip_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == 12'h144) |-> (csr_rdata & ~XLEN'(16'h0222)) == '0);
  // R10
  nohyp_gext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_HYP |-> mie_q[12] == 1'b0);
endmodule

bind hyp_irq_csr hyp_irq_csr_chk #(.XLEN(XLEN), .HAS_HYP(HAS_HYP)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .csr_hit(csr_hit), .irq_guest_ext(irq_guest_ext),
  .mie_q(mie_q)
);

// File: tb/hyp_irq_csr_bench.sv
`timescale 1ns/1ps
module hyp_irq_csr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, wmask = '0;
  logic msw = 0, mtm = 0, mex = 0, sex = 0, gex = 0;
  logic [63:0] rd0, rd1;
  logic hit0, hit1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hyp_irq_csr #(.XLEN(64), .HAS_HYP(1'b1)) u_hyp_irq_csr (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_addr(addr), .csr_wdata(wdata),
    .csr_wmask(wmask), .csr_rdata(rd0), .csr_hit(hit0), .irq_m_soft(msw),
    .irq_m_timer(mtm), .irq_m_ext(mex), .irq_s_ext(sex), .irq_guest_ext(gex));

  hyp_irq_csr #(.XLEN(64), .HAS_HYP(1'b0)) u_hyp_irq_csr_nohyp (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_addr(addr), .csr_wdata(wdata),
    .csr_wmask(wmask), .csr_rdata(rd1), .csr_hit(hit1), .irq_m_soft(msw),
    .irq_m_timer(mtm), .irq_m_ext(mex), .irq_s_ext(sex), .irq_guest_ext(gex));

  longint unsigned m_en[2], m_dl[2], m_sw[2];

  function automatic longint unsigned bitset(input int a, input int b, input int c);
    return (64'd1 << a) | (64'd1 << b) | (64'd1 << c);
  endfunction

  function automatic string tag_of(input int i, input logic [11:0] a);
    if (i == 1 && (a == 12'h604 || a == 12'h644 || a == 12'h645)) return "R10";
    case (a)
      12'h304: return "R2";
      12'h303: return (i == 1) ? "R10" : "R3";
      12'h604: return "R4";
      12'h144: return "R5";
      12'h644: return "R6";
      12'h645: return "R7";
      12'h344: return (i == 1) ? "R10" : "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_eval(input int i, output bit h, output longint unsigned r);
    bit hyp = (i == 0);
    longint unsigned s = bitset(1, 5, 9), vs = bitset(2, 6, 10);
    longint unsigned hs = vs | (64'd1 << 12);
    longint unsigned p = m_sw[i];
    if (msw) p |= 64'd1 << 3;
    if (mtm) p |= 64'd1 << 7;
    if (mex) p |= 64'd1 << 11;
    if (sex) p |= 64'd1 << 9;
    if (gex && hyp) p |= 64'd1 << 12;
    h = 0; r = 0;
    if (!en) return;
    if (addr == 12'h304) begin h = 1; r = m_en[i]; end
    else if (addr == 12'h303) begin h = 1; r = m_dl[i]; end
    else if (addr == 12'h344) begin h = 1; r = p; end
    else if (addr == 12'h144) begin h = 1; r = p & m_dl[i] & s; end
    else if (hyp && addr == 12'h604) begin h = 1; r = m_en[i] & hs; end
    else if (hyp && addr == 12'h644) begin h = 1; r = p & hs; end
    else if (hyp && addr == 12'h645) begin h = 1; r = p & vs; end
  endtask

  task automatic model_write(input int i);
    bit hyp = (i == 0);
    longint unsigned s = bitset(1, 5, 9), vs = bitset(2, 6, 10);
    longint unsigned hs = vs | (64'd1 << 12);
    longint unsigned m;
    bit h; longint unsigned r;
    model_eval(i, h, r);
    if (!h) return;
    case (addr)
      12'h304: begin
        m = wmask & (bitset(3, 7, 11) | s | hs);
        m_en[i] = (m_en[i] & ~m) | (wdata & m);
        if (!hyp) m_en[i] &= ~(64'd1 << 12);
      end
      12'h604: begin m = wmask & hs; m_en[i] = (m_en[i] & ~m) | (wdata & m); end
      12'h303: begin
        m = wmask & (s | vs);
        m_dl[i] = (m_dl[i] & ~m) | (wdata & m);
        if (hyp) m_dl[i] |= hs;
      end
      12'h344: begin m = wmask & (s | vs); m_sw[i] = (m_sw[i] & ~m) | (wdata & m); end
      12'h144: begin m = wmask & 64'd2 & m_dl[i]; m_sw[i] = (m_sw[i] & ~m) | (wdata & m); end
      12'h644: begin m = wmask & 64'd4; m_sw[i] = (m_sw[i] & ~m) | (wdata & m); end
      12'h645: begin m = wmask & vs; m_sw[i] = (m_sw[i] & ~m) | (wdata & m); end
      default: ;
    endcase
  endtask

  task automatic compare(input string force_tag);
    for (int i = 0; i < 2; i++) begin
      bit h; longint unsigned r;
      logic [63:0] ard = (i == 0) ? rd0 : rd1;
      logic ahit = (i == 0) ? hit0 : hit1;
      string t = (force_tag != "") ? force_tag : tag_of(i, addr);
      model_eval(i, h, r);
      checks++;
      if (ahit !== h || ard !== r) begin
        fails++;
        $display("FAIL %s inst=%0d addr=%h actual hit=%0b rdata=%h expected hit=%0b rdata=%h",
                 t, i, addr, ahit, ard, h, r);
      end
    end
  endtask

  task automatic step(input logic [11:0] a, input logic [63:0] d, input logic [63:0] m,
                      input string t);
    @(negedge clk);
    en = 1; addr = a; wdata = d; wmask = m;
    #1 compare(t);
    model_write(0); model_write(1);
  endtask

  initial begin
    m_en = '{0, 0}; m_sw = '{0, 0};
    m_dl[0] = bitset(2, 6, 10) | (64'd1 << 12); m_dl[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(12'h304, 0, 0, "R1");
    step(12'h303, 0, 0, "R1");
    step(12'h344, 0, 0, "R1");
    // R3: try to clear forced bits
    step(12'h303, 0, '1, "");
    step(12'h303, '1, '1, "");
    step(12'h303, 0, 0, "");
    // R2 / R10: full enable write, then read
    step(12'h304, '1, '1, "");
    step(12'h304, 0, 0, "");
    // R4: hie clear keeps machine bits
    step(12'h604, 0, '1, "");
    step(12'h304, 0, 0, "");
    // R8: hardware bits cannot be written
    step(12'h344, '1, '1, "");
    step(12'h344, 0, 0, "");
    // R5 / R6 / R7
    step(12'h144, 0, '1, "");
    step(12'h344, 0, 0, "");
    step(12'h644, '1, '1, "");
    step(12'h645, '1, '1, "");
    step(12'h644, 0, 0, "");
    // R9
    step(12'h300, '1, '1, "");
    step(12'h304, 0, 0, "");
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [63:0] d, m;
      int k = $urandom_range(0, 9);
      case (k)
        0: a = 12'h304; 1: a = 12'h303; 2: a = 12'h344; 3: a = 12'h144;
        4: a = 12'h604; 5: a = 12'h644; 6: a = 12'h645; 7: a = 12'h300;
        8: a = 12'h646; default: a = 12'($urandom);
      endcase
      d = {$urandom, $urandom};
      case ($urandom_range(0, 2))
        0: m = 0; 1: m = '1; default: m = {$urandom, $urandom};
      endcase
      @(negedge clk);
      msw = 1'($urandom); mtm = 1'($urandom); mex = 1'($urandom);
      sex = 1'($urandom); gex = 1'($urandom);
      en = ($urandom_range(0, 7) != 0);
      addr = a; wdata = d; wmask = m;
      #1 compare("");
      model_write(0); model_write(1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule